// File: doc/BRIEF.md
# Single-Action Timer Capture/Compare Channel

This block is one channel of a timer. It watches one of two free-running 16-bit time base buses. Software sets it up through a small register port. The channel then runs in one of four modes:

- In capture mode it latches the time base when a chosen edge arrives on a synchronized input pin. With capture switched off, it serves only as an input port.
- In the two compare modes it watches for the time base to equal a programmed value. On a match it either drives a chosen level onto the output pin or inverts that pin.
- In port mode software writes the output level directly.

Every capture or compare event raises an event flag, which can drive an interrupt line. Software clears the flag with a two-step handshake: first read the status/control register, then write a zero to the flag bit.

A single 16-bit data register holds both the captured time and the compare value. Software can read it at any time.

Top module: `tmr_cc_channel`

## Requirements
- R1: During and after reset, `pin_out` is 0, `irq` is 0, the data register reads 0 and the status/control register reads 0.
- R2: Status/control bit 4 selects the time base: 0 uses `tb_a` and 1 uses `tb_b`, for both capture and compare.
- R3: Capture mode is mode field bits [1:0] = 00. When bit 3 (capture enable) is 1, an input edge captures the selected time base into the data register and sets the flag. Bit 2 chooses the edge: 1 means rising, 0 means falling. A pin change applied before clock edge k is captured at edge k+2, using the time base value present during the cycle before edge k+2.
- R4: In capture mode with bit 3 = 0, input edges leave the data register and the flag unchanged.
- R5: In compare mode (mode 01), a cycle in which the selected time base equals the data register loads level bit 5 into `pin_out` at the end of that cycle and sets the flag.
- R6: In toggle mode (mode 10), each match cycle inverts `pin_out` and sets the flag.
- R7: In port mode (mode 11), a write to the status/control register loads bit 5 into `pin_out` at that write's clock edge. No compare acts in this mode.
- R8: Read-only status bit 8 shows the synchronized pin level in capture mode, and the `pin_out` level in the other three modes.
- R9: The flag is status bit 7. It clears only on a status write with bit 7 = 0 that comes after a status read made while the flag was set. Other accesses may come between the read and the write. Writing 1 to bit 7, or writing 0 without that earlier read, leaves the flag set.
- R10: When an event and a qualifying clearing write land on the same clock edge, the flag stays set.
- R11: `irq` is high exactly while the flag is set and interrupt-enable bit 6 is 1.
- R12: Register address 1 is the data register. Software can write it and read it back at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = status/control, 1 = data register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (combinational) |
| tb_a | input | 16 | Time base bus A |
| tb_b | input | 16 | Time base bus B |
| pin_in | input | 1 | Asynchronous input pin |
| pin_out | output | 1 | Output flip-flop level |
| irq | output | 1 | Interrupt request |

## Verification
Capture is tried with random edge polarity and random time-base selection. This separates the `tb_a` value from its complement on `tb_b` and exposes any error in the synchronizer latency. It also includes an edge of the wrong polarity, and an edge with capture disabled.

Compare and toggle runs use random match offsets and random levels. Matches are made on either bus, so a wrong bus or a wrong action shows on `pin_out`.

Directed sequences exercise the clearing handshake: a zero-write without a prior read, a one-write, a zero-write with an unrelated access in between, and a zero-write landing on the same edge as a match.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;
  typedef enum logic [1:0] {
    MD_CAPTURE = 2'b00,
    MD_MATCH   = 2'b01,
    MD_TOGGLE  = 2'b10,
    MD_PORT    = 2'b11
  } tcc_mode_e;

  localparam int B_EDGE  = 2;
  localparam int B_CAPEN = 3;
  localparam int B_TBSEL = 4;
  localparam int B_LEVEL = 5;
  localparam int B_IRQEN = 6;
  localparam int B_FLAG  = 7;
  localparam int B_IN    = 8;

  function automatic logic next_out(input tcc_mode_e md, input logic lvl, input logic cur);
    case (md)
      MD_MATCH:  return lvl;
      MD_TOGGLE: return ~cur;
      default:   return cur;
    endcase
  endfunction

  function automatic logic edge_hit(input logic rise, input logic now, input logic prev);
    return rise ? (now & ~prev) : (~now & prev);
  endfunction
endpackage

// File: rtl/tmr_cc_sync_edge.sv
module tmr_cc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic rise_sel,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign edge_o  = tmr_cc_pkg::edge_hit(rise_sel, chain_q[STAGES-1], prev_q);
endmodule

// File: rtl/tmr_cc_compare.sv
module tmr_cc_compare #(
  parameter int TW = 16
) (
  input  logic [TW-1:0] tb_a,
  input  logic [TW-1:0] tb_b,
  input  logic          sel_b,
  input  logic [TW-1:0] ref_val,
  output logic [TW-1:0] tb_val,
  output logic          match
);
  assign tb_val = sel_b ? tb_b : tb_a;
  assign match  = (tb_val == ref_val);
endmodule

// File: rtl/tmr_cc_flag.sv
module tmr_cc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic stat_rd,
  input  logic zero_wr,
  output logic flag_q,
  output logic armed_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_evt)                 flag_q <= 1'b1;
      else if (zero_wr && armed_q) flag_q <= 1'b0;
      if (zero_wr)                 armed_q <= 1'b0;
      else if (stat_rd && flag_q)  armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel
  import tmr_cc_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] rdata,
  input  logic [TW-1:0] tb_a,
  input  logic [TW-1:0] tb_b,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          irq
);
  localparam int STAT_W = B_IN + 1;

  tcc_mode_e    mode_q;
  logic         edge_q, capen_q, tbsel_q, level_q, irqen_q;
  logic [TW-1:0] data_q;
  logic         out_q;

  logic          sync_lvl, in_edge, match;
  logic [TW-1:0] tb_sel_val;
  logic          flag_q, armed_q;
  logic          ctrl_wr, data_wr, stat_rd, zero_wr;
  logic          cap_evt, cmp_evt, in_bit;
  logic [STAT_W-1:0] stat_word;

  assign ctrl_wr = wr_en && !addr;
  assign data_wr = wr_en && addr;
  assign stat_rd = rd_en && !addr;
  assign zero_wr = ctrl_wr && !wdata[B_FLAG];

  tmr_cc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .rise_sel(edge_q),
    .level_o(sync_lvl), .edge_o(in_edge)
  );

  tmr_cc_compare #(.TW(TW)) u_cmp (
    .tb_a(tb_a), .tb_b(tb_b), .sel_b(tbsel_q), .ref_val(data_q),
    .tb_val(tb_sel_val), .match(match)
  );

  assign cap_evt = (mode_q == MD_CAPTURE) && capen_q && in_edge;
  assign cmp_evt = ((mode_q == MD_MATCH) || (mode_q == MD_TOGGLE)) && match;

  tmr_cc_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(cap_evt || cmp_evt),
    .stat_rd(stat_rd), .zero_wr(zero_wr), .flag_q(flag_q), .armed_q(armed_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MD_CAPTURE;
      edge_q  <= 1'b0;
      capen_q <= 1'b0;
      tbsel_q <= 1'b0;
      level_q <= 1'b0;
      irqen_q <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q  <= tcc_mode_e'(wdata[1:0]);
      edge_q  <= wdata[B_EDGE];
      capen_q <= wdata[B_CAPEN];
      tbsel_q <= wdata[B_TBSEL];
      level_q <= wdata[B_LEVEL];
      irqen_q <= wdata[B_IRQEN];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       data_q <= '0;
    else if (cap_evt) data_q <= tb_sel_val;
    else if (data_wr) data_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      out_q <= 1'b0;
    else if (ctrl_wr && (wdata[1:0] == MD_PORT))
      out_q <= wdata[B_LEVEL];
    else if (cmp_evt)
      out_q <= next_out(mode_q, level_q, out_q);
  end

  assign in_bit    = (mode_q == MD_CAPTURE) ? sync_lvl : out_q;
  assign stat_word = {in_bit, flag_q, irqen_q, level_q, tbsel_q, capen_q, edge_q, mode_q};
  assign rdata     = addr ? data_q : TW'(stat_word);
  assign pin_out   = out_q;
  assign irq       = flag_q && irqen_q;
endmodule

// File: rtl/tmr_cc_channel_chk.sv
module tmr_cc_channel_chk
  import tmr_cc_pkg::*;
#(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          addr,
  input logic [TW-1:0] wdata,
  input logic          pin_out,
  input logic          irq,
  input logic          flag_q,
  input logic          armed_q,
  input logic          cap_evt,
  input logic          cmp_evt,
  input logic [TW-1:0] data_q,
  input logic [TW-1:0] tb_sel_val,
  input tcc_mode_e     mode_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (!pin_out && !flag_q));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(wr_en && !addr && !wdata[B_FLAG] && armed_q));

  // R10
  event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt || cmp_evt) |=> flag_q);

  // R3
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> data_q == $past(tb_sel_val));

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_TOGGLE && cmp_evt && !(wr_en && !addr)) |=> pin_out != $past(pin_out));

  // R11
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> flag_q);
endmodule

bind tmr_cc_channel tmr_cc_channel_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pin_out(pin_out), .irq(irq), .flag_q(flag_q), .armed_q(armed_q),
  .cap_evt(cap_evt), .cmp_evt(cmp_evt), .data_q(data_q),
  .tb_sel_val(tb_sel_val), .mode_q(mode_q)
);

// File: tb/tmr_cc_channel_tb.sv
`timescale 1ns/1ps
module tmr_cc_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] cnt = '0;
  logic        pin_in = 1'b0;
  logic        pin_out, irq;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 16'd1;

  tmr_cc_channel u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tb_a(cnt), .tb_b(~cnt),
    .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
  );

  function automatic logic [15:0] cfg(input logic [1:0] md, input logic rise, input logic capen,
                                      input logic tbsel, input logic lvl, input logic ien);
    return {8'h00, 1'b1, ien, lvl, tbsel, capen, rise, md};
  endfunction

  function automatic logic [15:0] sel_tb(input logic tbsel, input logic [15:0] c);
    return tbsel ? ~c : c;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a negedge
  task automatic wr(input logic a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    #0.5 d = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flag(input logic [15:0] c);
    logic [15:0] d;
    rd(1'b0, d);
    wr(1'b0, c & ~16'h0080);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, c0, v, c;
    logic lvl, rise, tsel;
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 pin_out in reset", {15'd0, pin_out}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    rd(1'b0, d); chk("R1 status", d, 16'd0);
    rd(1'b1, d); chk("R1 data", d, 16'd0);

    wr(1'b1, 16'h1234);
    rd(1'b1, d); chk("R12 data readback", d, 16'h1234);

    // R3 / R2 random capture
    for (int k = 0; k < 8; k++) begin
      rise = $urandom_range(1); tsel = $urandom_range(1);
      c = cfg(2'b00, rise, 1'b0, tsel, 1'b0, 1'b1);
      wr(1'b0, c);
      pin_in = ~rise; idle(4);
      rd(1'b0, d); chk("R8 in bit follows pin", {15'd0, d[8]}, {15'd0, ~rise});
      c[3] = 1'b1; wr(1'b0, c);
      clear_flag(c);
      chk("R9 flag cleared before capture", {15'd0, irq}, 16'd0);
      pin_in = rise; c0 = cnt;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      chk("R3 no flag before edge k+2", {15'd0, irq}, 16'd0);
      @(negedge clk);
      chk("R3 flag after capture", {15'd0, irq}, 16'd1);
      rd(1'b1, d); chk("R3 R2 captured value", d, sel_tb(tsel, c0 + 16'd2));
      clear_flag(c);
      pin_in = ~rise; idle(5);
      chk("R3 opposite edge ignored", {15'd0, irq}, 16'd0);
    end

    // R4 capture disabled
    rd(1'b1, v);
    c = cfg(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    wr(1'b0, c);
    pin_in = 1'b0; idle(4); pin_in = 1'b1; idle(5);
    chk("R4 no flag", {15'd0, irq}, 16'd0);
    rd(1'b1, d); chk("R4 data kept", d, v);
    rd(1'b0, d); chk("R8 in bit high", {15'd0, d[8]}, 16'd1);

    // R5 compare, R2 on either bus
    for (int k = 0; k < 6; k++) begin
      lvl = $urandom_range(1); tsel = $urandom_range(1);
      n = $urandom_range(8, 40);
      c = cfg(2'b01, 1'b0, 1'b0, tsel, lvl, 1'b1);
      wr(1'b1, sel_tb(tsel, cnt + 16'(n)));
      wr(1'b0, c);
      clear_flag(c);
      idle(n + 2);
      chk("R5 level loaded", {15'd0, pin_out}, {15'd0, lvl});
      chk("R5 flag set", {15'd0, irq}, 16'd1);
      rd(1'b0, d); chk("R8 in bit shows out", {15'd0, d[8]}, {15'd0, lvl});
      clear_flag(c);
    end

    // R6 toggle
    c = cfg(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    wr(1'b0, c);
    for (int k = 0; k < 4; k++) begin
      lvl = pin_out;
      n = $urandom_range(8, 30);
      wr(1'b1, cnt + 16'(n));
      clear_flag(c);
      idle(n + 2);
      chk("R6 toggled", {15'd0, pin_out}, {15'd0, ~lvl});
      chk("R6 flag", {15'd0, irq}, 16'd1);
    end

    // R11 enable masks irq
    wr(1'b0, cfg(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    chk("R11 irq masked", {15'd0, irq}, 16'd0);
    wr(1'b0, c);
    chk("R11 irq unmasked", {15'd0, irq}, 16'd1);

    // R9 handshake variants (flag set, armed consumed above)
    rd(1'b0, d); wr(1'b0, c & ~16'h0080);  // clear
    v = cnt + 16'd10; wr(1'b1, v); idle(14);
    chk("R9 flag set by match", {15'd0, irq}, 16'd1);
    wr(1'b0, c & ~16'h0080);
    chk("R9 zero without read ignored", {15'd0, irq}, 16'd1);
    rd(1'b0, d);
    wr(1'b0, c);
    chk("R9 write one ignored", {15'd0, irq}, 16'd1);
    rd(1'b1, d);
    wr(1'b0, c & ~16'h0080);
    chk("R9 cleared after read", {15'd0, irq}, 16'd0);

    // R10 event coincides with clear
    v = cnt + 16'd12; wr(1'b1, v); idle(14);
    chk("R10 setup flag", {15'd0, irq}, 16'd1);
    rd(1'b0, d);
    lvl = pin_out;
    v = cnt + 16'd10; wr(1'b1, v);
    while (cnt != v) @(negedge clk);
    wr(1'b0, c & ~16'h0080);
    chk("R10 flag stays", {15'd0, irq}, 16'd1);
    chk("R10 toggled", {15'd0, pin_out}, {15'd0, ~lvl});

    // R7 port mode
    wr(1'b0, cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    chk("R7 port high", {15'd0, pin_out}, 16'd1);
    rd(1'b0, d); chk("R8 in bit port", {15'd0, d[8]}, 16'd1);
    wr(1'b1, cnt + 16'd4);
    wr(1'b0, cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    chk("R7 port low", {15'd0, pin_out}, 16'd0);
    idle(8);
    chk("R7 no compare in port", {15'd0, pin_out}, 16'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule